// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Code Loader

This block is the digital front end of a two-channel, 256-step digitally controlled resistor. A host writes to it over a write-only three-wire serial link: an active-low select, a serial clock and a data line. While select is low, each rising serial-clock edge shifts one bit into a nine-bit input register. When select goes high again, the captured word is decoded. Its top bit picks one of two channels, and its low eight bits become that channel's wiper code.

The serial pins are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The system clock must run at least four times faster than the serial clock. Both wiper codes start at midscale after reset. Each channel has a one-cycle load strobe that marks the cycle in which its code changes. A frame that ends with fewer than nine bits is dropped. A frame with more than nine bits keeps only the last nine bits.

Top module: `dual_wiper_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both wiper codes equal midscale (0x80) and both load strobes are low.
- R2: A frame is nine bits sent most significant bit first. Bit 8 is the channel select: 0 writes `wiper0_code` and 1 writes `wiper1_code`. Bits 7..0 are the new code.
- R3: Serial-clock edges that occur while `cs_n` is high neither shift data nor cause any write.
- R4: A wiper code changes only after `cs_n` returns high. While `cs_n` is still low, the codes keep their old values even after nine or more bits have been clocked in.
- R5: When more than nine bits are clocked in one frame, the leading bits are discarded and the last nine bits received are decoded.
- R6: When `cs_n` rises after fewer than nine bits, the frame is discarded: no code changes and no strobe fires.
- R7: Each accepted frame raises exactly one load strobe, the one for the addressed channel, for exactly one system-clock cycle. The strobe is high in the first cycle that shows the new code.
- R8: The channel that a frame does not address keeps its code.
- R9: The bit count clears when `cs_n` falls, so bits from an earlier aborted frame never combine with a later frame. The count stops at nine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| cs_n | input | 1 | Active-low frame select; the rising edge commits the frame |
| sdin | input | 1 | Serial data in, MSB first |
| wiper0_code | output | 8 | Wiper code of channel 0 |
| wiper1_code | output | 8 | Wiper code of channel 1 |
| wiper0_load | output | 1 | One-cycle pulse when channel 0 is written |
| wiper1_load | output | 1 | One-cycle pulse when channel 1 is written |

## Verification
Writes go to each channel with mixed-bit codes and with the extreme codes 0x00 and 0xFF. These show whether the address bit and the MSB-first bit order are decoded correctly, and whether the other channel is left alone. A thirteen-bit frame with ones as its junk leading bits shows whether the register keeps only the newest nine bits. An eight-bit frame shows whether the length check works. A five-bit aborted frame followed by a four-bit aborted frame would commit only if the count failed to clear when select falls. Clock bursts sent with select high, and a check taken while select is still low after nine bits, show whether the design samples only inside a frame and commits only on the select rising edge.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int CODE_W = 8;
  localparam int WORD_W = CODE_W + 1;

  // Preset value: only the top code bit set
  function automatic logic [CODE_W-1:0] mid_code();
    return {1'b1, {(CODE_W-1){1'b0}}};
  endfunction

  function automatic logic word_addr(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= rst_val;
          else        stage[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= rst_val;
          else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wl_frame_rx.sv
module wl_frame_rx #(
  parameter int WORD_W = 9,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  output logic              sclk_rise,
  output logic              cs_active,
  output logic              cs_rise,
  output logic              frame_full,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] word
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic sclk_q, csn_q;
  logic cs_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end

  assign sclk_rise  = sclk_s & ~sclk_q;
  assign cs_fall    = ~csn_s & csn_q;
  assign cs_rise    = csn_s & ~csn_q;
  assign cs_active  = ~csn_s;
  assign frame_full = (bit_cnt == FULL_CNT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      word    <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      word    <= '0;
    end else if (cs_active && sclk_rise) begin
      word <= {word[WORD_W-2:0], sdi_s};
      if (!frame_full) bit_cnt <= bit_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/wl_wiper_bank.sv
module wl_wiper_bank #(
  parameter int NCH    = 2,
  parameter int CODE_W = 8,
  parameter int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] preset,
  output logic [CODE_W-1:0] wiper [NCH],
  output logic [NCH-1:0]    load
);
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = commit && (addr == ADDR_W'(c));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          wiper[c] <= preset;
          load[c]  <= 1'b0;
        end else begin
          load[c] <= hit;
          if (hit) wiper[c] <= code;
        end
    end
  endgenerate
endmodule

// File: rtl/dual_wiper_loader.sv
module dual_wiper_loader (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdin,
  output logic [7:0] wiper0_code,
  output logic [7:0] wiper1_code,
  output logic       wiper0_load,
  output logic       wiper1_load
);
  import wl_pkg::*;
  localparam int NCH         = 2;
  localparam int SYNC_STAGES = 2;
  localparam int CNT_W       = $clog2(WORD_W + 1);

  // {cs_n, sclk, sdin}, idle values during reset
  logic [2:0] pins_s;
  wl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdin}),
    .rst_val(3'b100), .q(pins_s)
  );

  // Named internal events, observed by the bound checker
  logic              sclk_rise_w, cs_active_w, cs_rise_w, frame_full_w;
  logic [CNT_W-1:0]  bit_cnt_w;
  logic [WORD_W-1:0] word_w;
  logic              commit_w;

  wl_frame_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .csn_s(pins_s[2]), .sdi_s(pins_s[0]),
    .sclk_rise(sclk_rise_w), .cs_active(cs_active_w), .cs_rise(cs_rise_w),
    .frame_full(frame_full_w), .bit_cnt(bit_cnt_w), .word(word_w)
  );

  assign commit_w = cs_rise_w & frame_full_w;

  logic [CODE_W-1:0] wipers [NCH];
  logic [NCH-1:0]    loads;

  wl_wiper_bank #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(1)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit_w),
    .addr(word_addr(word_w)), .code(word_code(word_w)),
    .preset(mid_code()), .wiper(wipers), .load(loads)
  );

  assign wiper0_code = wipers[0];
  assign wiper1_code = wipers[1];
  assign wiper0_load = loads[0];
  assign wiper1_load = loads[1];
endmodule

// File: rtl/wl_checker.sv
module wl_checker #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 4,
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              cs_active,
  input logic              cs_rise,
  input logic              frame_full,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CODE_W-1:0] w0,
  input logic [CODE_W-1:0] w1,
  input logic              ld0,
  input logic              ld1
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  // R1
  rst_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (w0 == MID && w1 == MID && !ld0 && !ld1));

  // R3
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_active) |=> $stable(bit_cnt));

  // R6
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_full) |=> (!ld0 && !ld1));

  // R7
  strobe_pulse0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> !ld0);

  // R7
  strobe_pulse1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> !ld1);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld0 && ld1));

  // R8
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(w0) |-> ld0);

  // R8
  hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(w1) |-> ld1);

  // R9
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));
endmodule

bind dual_wiper_loader wl_checker #(.CODE_W(8), .CNT_W(4), .WORD_W(9)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise_w), .cs_active(cs_active_w),
  .cs_rise(cs_rise_w), .frame_full(frame_full_w), .bit_cnt(bit_cnt_w),
  .w0(wiper0_code), .w1(wiper1_code), .ld0(wiper0_load), .ld1(wiper1_load)
);

// File: tb/dual_wiper_loader_tb.sv
`timescale 1ns/1ps
module dual_wiper_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdin = 1'b0;
  logic [7:0] wiper0_code, wiper1_code;
  logic wiper0_load, wiper1_load;

  int checks = 0;
  int errors = 0;
  int hi0 = 0;
  int hi1 = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_wiper_loader u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
    .wiper0_code(wiper0_code), .wiper1_code(wiper1_code),
    .wiper0_load(wiper0_load), .wiper1_load(wiper1_load)
  );

  // Count strobe-high cycles, sampled away from the active edge
  always @(negedge clk) begin
    if (wiper0_load) hi0++;
    if (wiper1_load) hi1++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Select low, then shift n bits of v, MSB first; select stays low
  task automatic shift_bits(logic [15:0] v, int n);
    cs_n = 1'b0;
    #80;
    for (int i = n - 1; i >= 0; i--) begin
      sdin = v[i];
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    #40;
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    #200;
  endtask

  task automatic clear_strobes();
    hi0 = 0;
    hi1 = 0;
  endtask

  task automatic t_reset();
    check("R1 wiper0 after reset", wiper0_code, 8'h80);
    check("R1 wiper1 after reset", wiper1_code, 8'h80);
    check("R1 no strobe after reset", hi0 + hi1, 0);
  endtask

  task automatic t_write_ch0();
    clear_strobes();
    shift_bits(16'h003C, 9);
    #200;
    check("R4 wiper0 held while select low", wiper0_code, 8'h80);
    close_frame();
    check("R2 wiper0 written", wiper0_code, 8'h3C);
    check("R8 wiper1 kept", wiper1_code, 8'h80);
    check("R7 wiper0 strobe one cycle", hi0, 1);
    check("R7 no wiper1 strobe", hi1, 0);
  endtask

  task automatic t_write_ch1();
    clear_strobes();
    shift_bits(16'h01A5, 9);
    close_frame();
    check("R2 wiper1 written", wiper1_code, 8'hA5);
    check("R8 wiper0 kept", wiper0_code, 8'h3C);
    check("R7 wiper1 strobe one cycle", hi1, 1);
    check("R7 no wiper0 strobe", hi0, 0);
  endtask

  task automatic t_extremes();
    shift_bits(16'h0000, 9);
    close_frame();
    check("R2 wiper0 zero code", wiper0_code, 8'h00);
    shift_bits(16'h01FF, 9);
    close_frame();
    check("R2 wiper1 full code", wiper1_code, 8'hFF);
    check("R8 wiper0 kept zero", wiper0_code, 8'h00);
  endtask

  task automatic t_long_frame();
    clear_strobes();
    shift_bits({3'b000, 4'hF, 9'h055}, 13);
    close_frame();
    check("R5 last nine bits used", wiper0_code, 8'h55);
    check("R5 wiper1 unaffected", wiper1_code, 8'hFF);
    check("R5 single strobe", hi0 + hi1, 1);
  endtask

  task automatic t_short_frame();
    clear_strobes();
    shift_bits(16'h00AA, 8);
    close_frame();
    check("R6 short frame wiper0", wiper0_code, 8'h55);
    check("R6 short frame wiper1", wiper1_code, 8'hFF);
    check("R6 short frame no strobe", hi0 + hi1, 0);
  endtask

  task automatic t_split_frame();
    clear_strobes();
    shift_bits(16'h0010, 5);
    close_frame();
    shift_bits(16'h0003, 4);
    close_frame();
    check("R9 split frames wiper0", wiper0_code, 8'h55);
    check("R9 split frames wiper1", wiper1_code, 8'hFF);
    check("R9 split frames no strobe", hi0 + hi1, 0);
  endtask

  task automatic t_idle_clocks();
    clear_strobes();
    for (int i = 0; i < 9; i++) begin
      sdin = i[0];
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    #200;
    check("R3 idle clocks wiper0", wiper0_code, 8'h55);
    check("R3 idle clocks wiper1", wiper1_code, 8'hFF);
    check("R3 idle clocks no strobe", hi0 + hi1, 0);
    shift_bits(16'h0111, 9);
    close_frame();
    check("R3 frame after idle clocks", wiper1_code, 8'h11);
  endtask

  initial begin
    #1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wiper0 first cycle after reset", wiper0_code, 8'h80);
    repeat (4) @(negedge clk);
    t_write_ch0();
    t_write_ch1();
    t_extremes();
    t_long_frame();
    t_short_frame();
    t_split_frame();
    t_idle_clocks();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule